// File: doc/BRIEF.md
# Process ID Address Relocation Stage

This block sits in front of a page-table translation unit. It rewrites virtual addresses that fall in the lowest 32 MB of the address space, using a small process identifier register. When the seven most significant address bits are all zero, the stage replaces them with the current process identifier. Each process therefore runs in the same low window but lands in its own private 32 MB region before translation. Any other address leaves the stage as it entered.

A context switch is a single write to the identifier register. No cache or table flush goes with it, because relocated addresses from different processes never alias. An identifier of zero leaves the low window where it is. The 127 nonzero identifiers give 127 separate windows.

Requests flow through one registered stage with a valid/ready handshake. A register port writes the identifier and reads it back as a 32-bit register image.

Top module: `pid_reloc_stage`

## Requirements
- R1: After synchronous reset, `out_valid` is 0 and `pid_rd_data` reads 0x00000000.
- R2: An accepted address whose bits [31:25] are all zero leaves the stage with bits [31:25] equal to the process identifier in force when it was accepted.
- R3: An accepted address with any of bits [31:25] set (0x02000000 and above) leaves the stage unchanged.
- R4: Bits [24:0] of every address leave the stage equal to those of the accepted input.
- R5: With the identifier at zero, addresses in the window 0x00000000 to 0x01FFFFFF leave the stage unchanged.
- R6: An identifier write applies to requests accepted at a later clock edge. A request accepted on the same edge as the write uses the old identifier, and a request already held in the stage keeps its address.
- R7: `pid_rd_data` holds the identifier in bits [31:25], with bits [24:0] reading zero. It shows a written value from the cycle after the write edge.
- R8: An accepted request appears on `out_valid` one cycle later. While `out_ready` is low, `out_valid` and `out_addr` hold steady.
- R9: `in_ready` is high exactly when the stage is empty or `out_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input address valid |
| in_ready | output | 1 | Stage can accept an address |
| in_addr | input | 32 | Virtual address before relocation |
| out_valid | output | 1 | Output address valid |
| out_ready | input | 1 | Translation stage accepts the address |
| out_addr | output | 32 | Address passed to page-table translation |
| pid_wr_en | input | 1 | Write strobe for the identifier register |
| pid_wr_data | input | 7 | New process identifier |
| pid_rd_data | output | 32 | Identifier register image, identifier in bits [31:25] |

## Verification
A wrong identifier register shows up at two ports. The read-back image is wrong on the cycle after the write, and the top seven bits of the next low-window address are wrong one cycle after that address is accepted. A stale or early identifier sample affects only requests accepted on the write edge. The bench therefore drives writes and requests on the same cycle, and on adjacent cycles. A fault in the held register under backpressure changes `out_addr` while `out_valid` is stalled, so it is seen on the next cycle.

// File: rtl/pid_reloc_pkg.sv
package pid_reloc_pkg;
    localparam int DEF_ADDR_W = 32;
    localparam int DEF_PID_W  = 7;

    typedef struct packed {
        logic                                seg;
        logic [DEF_ADDR_W-DEF_PID_W-1:0]     off;
    } unused_guard_t;

    // Relocate one address of default width.
    function automatic logic [DEF_ADDR_W-1:0] relocate_default(
        input logic [DEF_ADDR_W-1:0] addr,
        input logic [DEF_PID_W-1:0]  pid
    );
        logic [DEF_ADDR_W-1:0] r;
        r = addr;
        if (addr[DEF_ADDR_W-1 -: DEF_PID_W] == '0)
            r[DEF_ADDR_W-1 -: DEF_PID_W] = pid;
        return r;
    endfunction
endpackage

// File: rtl/pid_reloc_regfile.sv
module pid_reloc_regfile #(
    parameter int ADDR_W = pid_reloc_pkg::DEF_ADDR_W,
    parameter int PID_W  = pid_reloc_pkg::DEF_PID_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PID_W-1:0]  wr_data,
    output logic [PID_W-1:0]  pid,
    output logic [ADDR_W-1:0] image
);
    localparam int OFF_W = ADDR_W - PID_W;

    logic [PID_W-1:0] pid_q;

    always_ff @(posedge clk) begin
        if (rst)
            pid_q <= '0;
        else if (wr_en)
            pid_q <= wr_data;
    end

    assign pid   = pid_q;
    assign image = {pid_q, {OFF_W{1'b0}}};
endmodule

// File: rtl/pid_reloc_map.sv
module pid_reloc_map #(
    parameter int ADDR_W = pid_reloc_pkg::DEF_ADDR_W,
    parameter int PID_W  = pid_reloc_pkg::DEF_PID_W
) (
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [PID_W-1:0]  pid,
    output logic [ADDR_W-1:0] raddr
);
    localparam int OFF_W = ADDR_W - PID_W;

    logic [PID_W-1:0] seg;
    logic [OFF_W-1:0] off;
    logic             in_window;

    assign seg       = vaddr[ADDR_W-1 -: PID_W];
    assign off       = vaddr[OFF_W-1:0];
    assign in_window = (seg == '0);

    always_comb begin
        raddr = {(in_window ? pid : seg), off};
    end
endmodule

// File: rtl/pid_reloc_pipe.sv
module pid_reloc_pipe #(
    parameter int DATA_W = pid_reloc_pkg::DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [DATA_W-1:0] m_data
);
    logic              vld_q;
    logic [DATA_W-1:0] dat_q;

    assign s_ready = !vld_q || m_ready;

    always_ff @(posedge clk) begin
        if (rst)
            vld_q <= 1'b0;
        else if (s_ready)
            vld_q <= s_valid;
    end

    always_ff @(posedge clk) begin
        if (s_valid && s_ready)
            dat_q <= s_data;
    end

    assign m_valid = vld_q;
    assign m_data  = dat_q;
endmodule

// File: rtl/pid_reloc_stage.sv
module pid_reloc_stage #(
    parameter int ADDR_W = pid_reloc_pkg::DEF_ADDR_W,
    parameter int PID_W  = pid_reloc_pkg::DEF_PID_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    input  logic              pid_wr_en,
    input  logic [PID_W-1:0]  pid_wr_data,
    output logic [ADDR_W-1:0] pid_rd_data
);
    logic [PID_W-1:0]  pid_cur;
    logic [ADDR_W-1:0] mapped;

    pid_reloc_regfile #(.ADDR_W(ADDR_W), .PID_W(PID_W)) regs_i (
        .clk(clk), .rst(rst), .wr_en(pid_wr_en), .wr_data(pid_wr_data),
        .pid(pid_cur), .image(pid_rd_data)
    );

    pid_reloc_map #(.ADDR_W(ADDR_W), .PID_W(PID_W)) map_i (
        .vaddr(in_addr), .pid(pid_cur), .raddr(mapped)
    );

    pid_reloc_pipe #(.DATA_W(ADDR_W)) pipe_i (
        .clk(clk), .rst(rst),
        .s_valid(in_valid), .s_ready(in_ready), .s_data(mapped),
        .m_valid(out_valid), .m_ready(out_ready), .m_data(out_addr)
    );
endmodule

// File: rtl/pid_reloc_chk.sv
module pid_reloc_chk #(
    parameter int ADDR_W = 32,
    parameter int PID_W  = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [ADDR_W-1:0] in_addr,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_addr,
    input logic              pid_wr_en,
    input logic [PID_W-1:0]  pid_wr_data,
    input logic [ADDR_W-1:0] pid_rd_data
);
    localparam int OFF_W = ADDR_W - PID_W;

    p_reloc_low_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_addr[ADDR_W-1 -: PID_W] == '0)
        |=> out_addr[ADDR_W-1 -: PID_W] == $past(pid_rd_data[ADDR_W-1 -: PID_W]));

    p_pass_high_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_addr[ADDR_W-1 -: PID_W] != '0)
        |=> out_addr == $past(in_addr));

    p_offset_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (out_valid && out_addr[OFF_W-1:0] == $past(in_addr[OFF_W-1:0])));

    p_pid_image_r7: assert property (@(posedge clk) disable iff (rst)
        pid_wr_en |=> pid_rd_data == {$past(pid_wr_data), {OFF_W{1'b0}}});

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));

    p_ready_r9: assert property (@(posedge clk) disable iff (rst)
        in_ready == (!out_valid || out_ready));
endmodule

bind pid_reloc_stage pid_reloc_chk #(.ADDR_W(ADDR_W), .PID_W(PID_W)) chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .pid_wr_en(pid_wr_en), .pid_wr_data(pid_wr_data),
    .pid_rd_data(pid_rd_data)
);

// File: tb/pid_reloc_stage_tb_top.sv
module pid_reloc_stage_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_addr = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_addr;
    logic        pid_wr_en = 1'b0;
    logic [6:0]  pid_wr_data = '0;
    logic [31:0] pid_rd_data;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    logic [6:0]  model_pid = '0;
    logic [31:0] exp_q[$];
    logic [31:0] src_q[$];
    logic        held_v = 0;
    logic [31:0] held_a = '0;

    always #10 clk = ~clk;

    pid_reloc_stage dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .pid_wr_en(pid_wr_en), .pid_wr_data(pid_wr_data),
        .pid_rd_data(pid_rd_data)
    );

    function automatic logic [31:0] exp_addr(input logic [31:0] a, input logic [6:0] p);
        return (a[31:25] == 7'd0) ? {p, a[24:0]} : a;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, expv);
        end
    endtask

    // Called late in a cycle: inputs and registered outputs are stable.
    task automatic monitor();
        logic [31:0] e, s;
        chk(in_ready == (!out_valid || out_ready), "R9 ready", {31'd0, in_ready}, {31'd0, (!out_valid || out_ready)});
        chk(pid_rd_data == {model_pid, 25'd0}, "R7 image", pid_rd_data, {model_pid, 25'd0});
        if (held_v) begin
            chk(out_valid && out_addr == held_a, "R8 hold", out_addr, held_a);
        end
        held_v = out_valid && !out_ready;
        held_a = out_addr;
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk(0, "R8 unexpected output", out_addr, 32'hxxxxxxxx);
            end else begin
                e = exp_q.pop_front();
                s = src_q.pop_front();
                chk(out_addr[24:0] == s[24:0], "R4 offset", out_addr, s);
                if (s[31:25] != 0)
                    chk(out_addr == e, "R3 pass", out_addr, e);
                else if (e[31:25] == 0)
                    chk(out_addr == e, "R5 zero pid", out_addr, e);
                else
                    chk(out_addr == e, "R2/R6 reloc", out_addr, e);
            end
        end
        if (in_valid && in_ready) begin
            exp_q.push_back(exp_addr(in_addr, model_pid));
            src_q.push_back(in_addr);
        end
        if (pid_wr_en) model_pid = pid_wr_data;
    endtask

    task automatic cyc(input bit v, input logic [31:0] a, input bit rdy, input bit we, input logic [6:0] wd);
        @(negedge clk);
        in_valid = v; in_addr = a; out_ready = rdy; pid_wr_en = we; pid_wr_data = wd;
        #8;
        monitor();
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        #8;
        chk(out_valid == 1'b0, "R1 valid", {31'd0, out_valid}, 32'd0);
        chk(pid_rd_data == 32'd0, "R1 image", pid_rd_data, 32'd0);
        @(negedge clk); rst = 1'b0;
        // R5: identifier zero, low window untouched
        cyc(1, 32'h0012_3456, 1, 0, 0);
        cyc(1, 32'h01FF_FFFF, 1, 0, 0);
        // R7: write 0x7F
        cyc(0, 0, 1, 1, 7'h7F);
        cyc(1, 32'h0000_0000, 1, 0, 0);   // R2 -> FE000000
        cyc(1, 32'h01FF_FFFF, 1, 0, 0);   // R2 -> FFFFFFFF
        cyc(1, 32'h0200_0000, 1, 0, 0);   // R3 boundary pass
        cyc(1, 32'hFFFF_FFFF, 1, 0, 0);   // R3
        // R6: write on same edge as acceptance uses old (7F); next uses 05
        cyc(1, 32'h0000_0ABC, 1, 1, 7'h05);
        cyc(1, 32'h0000_0ABC, 1, 0, 0);
        // R6/R8: held request during write keeps its address
        cyc(1, 32'h0100_0001, 0, 0, 0);
        cyc(0, 0, 0, 1, 7'h33);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0);
        cyc(1, 32'h0100_0001, 1, 0, 0);
        cyc(0, 0, 1, 0, 0);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] a;
            a = $urandom();
            if ($urandom_range(1, 0) == 1) a[31:25] = 7'd0;
            cyc($urandom_range(3, 0) != 0, a, $urandom_range(3, 0) != 0,
                $urandom_range(15, 0) == 0, 7'($urandom()));
        end
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 0);
        chk(exp_q.size() == 0, "R8 drained", exp_q.size(), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule